// File: doc/BRIEF.md
# Inter-Thread Stride Detector

This block watches the demand memory requests of a many-threaded core. Each request carries the program counter of the load, the address it touches and the identifier of the issuing thread. In data-parallel code the address a thread touches is usually a linear function of its thread identifier. The block learns, separately for each load instruction, the constant number of bytes between the addresses of threads whose identifiers differ by one. The stride is taken from the ratio of the address difference to the thread-identifier difference between requests from different threads. It is not taken from successive addresses of a single thread.

A small table holds one entry per tracked program counter, and a miss replaces entries in turn. An entry goes through three stages: an anchor request, a candidate stride from an exactly divisible pair, and locked. An entry locks only when a third request agrees with both earlier ones. While an entry is locked, each further request at that program counter produces one prefetch address. That address points at the data a thread a fixed number of identifiers ahead will need, which by default is one warp of 32 threads. Sending the prefetch to memory is handled elsewhere.

Top module: `xthread_stride_pf`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `pf_valid` is 0.
- R2: Table entries are selected by `dem_pc`. Requests for different program counters train independently even when they are interleaved cycle by cycle.
- R3: A candidate stride is taken from a pair of requests only when the address difference divides exactly by the thread-identifier difference. A pair that does not divide exactly discards the older request and makes the newer one the anchor.
- R4: An entry locks only when three requests agree. The newest request must match the candidate stride against both the second request and the anchor. A prefetch appears no earlier than the third request of a pattern.
- R5: The prefetch address is the demand address plus the stride multiplied by `THREAD_DIST`, modulo 2^`ADDR_W`. It is presented with `pf_valid` high in the cycle after the edge that samples the triggering request.
- R6: A request whose thread identifier equals that of the stored comparison request does not change training. On a locked entry such a request still produces a prefetch and leaves the stored comparison request unchanged.
- R7: On a locked or candidate entry, a request whose address difference does not equal stride × thread-identifier difference produces no prefetch. The entry drops back to the anchor stage with that request as its new anchor, so three fresh agreeing requests are needed before the next prefetch.
- R8: A request whose program counter misses the table allocates an entry, chosen round-robin over `ENTRIES` slots, and produces no prefetch. With 16 entries, a locked entry survives 15 further allocations and is replaced by the 16th.
- R9: At most one prefetch is produced per cycle. `pf_valid` is 0 in any cycle that does not follow a sampled demand request.
- R10: Strides are signed. Requests whose addresses fall as the thread identifier grows lock to a negative stride and prefetch downward in address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dem_valid | input | 1 | A demand request is present this cycle |
| dem_pc | input | PC_W | Program counter of the demand load |
| dem_addr | input | ADDR_W | Byte address of the demand access |
| dem_tid | input | TID_W | Identifier of the requesting thread |
| pf_valid | output | 1 | A prefetch address is presented this cycle |
| pf_addr | output | ADDR_W | Prefetch byte address |

## Verification
The only result the block produces is the prefetch, and it is due exactly one clock after the edge that samples the demand request. The table update and the prefetch register load on that same edge. Each scenario task drives a request at a falling edge and reads `pf_valid` and `pf_addr` at the next falling edge, midway between the sampling edge and the following one. One idle cycle then follows each request, so the bench can confirm that `pf_valid` drops when no request is present. Effects on the table, such as retraining, ignored requests and eviction, are observed one request later through whether that later request produces a prefetch.

// File: rtl/xts_pkg.sv
package xts_pkg;

    // Training stage of one table entry
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_ANCHOR = 2'd1,
        ST_PAIR   = 2'd2,
        ST_LOCKED = 2'd3
    } ent_stage_e;

endpackage

// File: rtl/xts_pc_match.sv
module xts_pc_match #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [PC_W-1:0]               req_pc,
    input  logic [ENTRIES-1:0]            live,
    input  logic [ENTRIES-1:0][PC_W-1:0]  ent_pc,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          hit_any,
    output logic [IDX_W-1:0]              hit_idx
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = live[i] && (ent_pc[i] == req_pc);
    end

    assign hit_any = |hit_vec;

    // Lowest matching slot wins
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xts_victim.sv
module xts_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            if (ptr_q == IDX_W'(ENTRIES - 1)) begin
                ptr_d = '0;
            end else begin
                ptr_d = ptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign idx = ptr_q;

endmodule

// File: rtl/xts_train.sv
module xts_train
    import xts_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int TID_W       = 10,
    parameter int THREAD_DIST = 32
) (
    input  ent_stage_e               cur_stage,
    input  logic [ADDR_W-1:0]        anc_addr,
    input  logic [TID_W-1:0]         anc_tid,
    input  logic [ADDR_W-1:0]        lst_addr,
    input  logic [TID_W-1:0]         lst_tid,
    input  logic signed [ADDR_W-1:0] cur_stride,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [TID_W-1:0]         req_tid,
    output ent_stage_e               nxt_stage,
    output logic [ADDR_W-1:0]        nxt_anc_addr,
    output logic [TID_W-1:0]         nxt_anc_tid,
    output logic [ADDR_W-1:0]        nxt_lst_addr,
    output logic [TID_W-1:0]         nxt_lst_tid,
    output logic signed [ADDR_W-1:0] nxt_stride,
    output logic                     fire,
    output logic [ADDR_W-1:0]        fire_addr
);

    localparam int PW = ADDR_W + TID_W + 2;
    localparam logic signed [ADDR_W-1:0] DIST_S = ADDR_W'(THREAD_DIST);

    // Differences against the anchor and the last accepted request
    logic signed [ADDR_W:0]  da_anc, da_lst;
    logic signed [TID_W:0]   dt_anc, dt_lst;
    logic signed [PW-1:0]    da_anc_x, da_lst_x, dt_anc_x, dt_lst_x, str_x;
    logic signed [PW-1:0]    prod_anc, prod_lst;
    logic signed [PW-1:0]    divisor, quo, quo_back;
    logic                    ok_anc, ok_lst, exact, fits;
    logic signed [ADDR_W-1:0] jump;

    always_comb begin
        da_anc = $signed({1'b0, req_addr}) - $signed({1'b0, anc_addr});
        da_lst = $signed({1'b0, req_addr}) - $signed({1'b0, lst_addr});
        dt_anc = $signed({1'b0, req_tid}) - $signed({1'b0, anc_tid});
        dt_lst = $signed({1'b0, req_tid}) - $signed({1'b0, lst_tid});

        da_anc_x = {{(PW-ADDR_W-1){da_anc[ADDR_W]}}, da_anc};
        da_lst_x = {{(PW-ADDR_W-1){da_lst[ADDR_W]}}, da_lst};
        dt_anc_x = {{(PW-TID_W-1){dt_anc[TID_W]}}, dt_anc};
        dt_lst_x = {{(PW-TID_W-1){dt_lst[TID_W]}}, dt_lst};
        str_x    = {{(PW-ADDR_W){cur_stride[ADDR_W-1]}}, cur_stride};

        // Agreement test by multiplication, no division needed
        prod_anc = str_x * dt_anc_x;
        prod_lst = str_x * dt_lst_x;
        ok_anc   = (prod_anc == da_anc_x);
        ok_lst   = (prod_lst == da_lst_x);

        // Candidate stride from the first pair, kept only when exact
        divisor  = (dt_anc_x == '0) ? PW'(1) : dt_anc_x;
        quo      = da_anc_x / divisor;
        quo_back = quo * divisor;
        exact    = (quo_back == da_anc_x);
        fits     = (quo[PW-1:ADDR_W-1] == '0) || (quo[PW-1:ADDR_W-1] == '1);

        jump      = cur_stride * DIST_S;
        fire_addr = req_addr + jump;
    end

    always_comb begin
        nxt_stage    = cur_stage;
        nxt_anc_addr = anc_addr;
        nxt_anc_tid  = anc_tid;
        nxt_lst_addr = lst_addr;
        nxt_lst_tid  = lst_tid;
        nxt_stride   = cur_stride;
        fire         = 1'b0;

        unique case (cur_stage)
            ST_ANCHOR: begin
                if (dt_anc == '0) begin
                    // same thread as the anchor: nothing learned
                end else if (exact && fits) begin
                    nxt_stage    = ST_PAIR;
                    nxt_stride   = quo[ADDR_W-1:0];
                    nxt_lst_addr = req_addr;
                    nxt_lst_tid  = req_tid;
                end else begin
                    nxt_anc_addr = req_addr;
                    nxt_anc_tid  = req_tid;
                end
            end
            ST_PAIR: begin
                if (dt_lst == '0) begin
                    // ignored for training
                end else if (ok_lst && ok_anc) begin
                    nxt_stage    = ST_LOCKED;
                    nxt_lst_addr = req_addr;
                    nxt_lst_tid  = req_tid;
                    fire         = 1'b1;
                end else begin
                    nxt_stage    = ST_ANCHOR;
                    nxt_anc_addr = req_addr;
                    nxt_anc_tid  = req_tid;
                end
            end
            ST_LOCKED: begin
                if (dt_lst == '0) begin
                    fire = 1'b1;
                end else if (ok_lst) begin
                    nxt_lst_addr = req_addr;
                    nxt_lst_tid  = req_tid;
                    fire         = 1'b1;
                end else begin
                    nxt_stage    = ST_ANCHOR;
                    nxt_anc_addr = req_addr;
                    nxt_anc_tid  = req_tid;
                end
            end
            default: begin
                // free entries are never selected by a hit
            end
        endcase
    end

endmodule

// File: rtl/xthread_stride_pf.sv
module xthread_stride_pf
    import xts_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int ADDR_W      = 32,
    parameter int TID_W       = 10,
    parameter int ENTRIES     = 16,
    parameter int THREAD_DIST = 32,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dem_valid,
    input  logic [PC_W-1:0]   dem_pc,
    input  logic [ADDR_W-1:0] dem_addr,
    input  logic [TID_W-1:0]  dem_tid,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    typedef struct packed {
        ent_stage_e               stage;
        logic [PC_W-1:0]          pc;
        logic [ADDR_W-1:0]        anc_addr;
        logic [TID_W-1:0]         anc_tid;
        logic [ADDR_W-1:0]        lst_addr;
        logic [TID_W-1:0]         lst_tid;
        logic signed [ADDR_W-1:0] stride;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tab;
        logic                 pf_v;
        logic [ADDR_W-1:0]    pf_a;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]           live, hit_vec, locked_vec, pair_vec;
    logic [ENTRIES-1:0][PC_W-1:0] ent_pc;
    logic                         hit_any, alloc;
    logic [IDX_W-1:0]             hit_idx, vic_idx;
    entry_t                       sel;

    ent_stage_e               tr_stage;
    logic [ADDR_W-1:0]        tr_anc_addr, tr_lst_addr, tr_pf_addr;
    logic [TID_W-1:0]         tr_anc_tid, tr_lst_tid;
    logic signed [ADDR_W-1:0] tr_stride;
    logic                     tr_fire;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            live[i]       = (st_q.tab[i].stage != ST_FREE);
            locked_vec[i] = (st_q.tab[i].stage == ST_LOCKED);
            pair_vec[i]   = (st_q.tab[i].stage == ST_PAIR);
            ent_pc[i]     = st_q.tab[i].pc;
        end
    end

    xts_pc_match #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W)
    ) u_match (
        .req_pc  (dem_pc),
        .live    (live),
        .ent_pc  (ent_pc),
        .hit_vec (hit_vec),
        .hit_any (hit_any),
        .hit_idx (hit_idx)
    );

    xts_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (alloc),
        .idx     (vic_idx)
    );

    assign sel = st_q.tab[hit_idx];

    xts_train #(
        .ADDR_W      (ADDR_W),
        .TID_W       (TID_W),
        .THREAD_DIST (THREAD_DIST)
    ) u_train (
        .cur_stage    (sel.stage),
        .anc_addr     (sel.anc_addr),
        .anc_tid      (sel.anc_tid),
        .lst_addr     (sel.lst_addr),
        .lst_tid      (sel.lst_tid),
        .cur_stride   (sel.stride),
        .req_addr     (dem_addr),
        .req_tid      (dem_tid),
        .nxt_stage    (tr_stage),
        .nxt_anc_addr (tr_anc_addr),
        .nxt_anc_tid  (tr_anc_tid),
        .nxt_lst_addr (tr_lst_addr),
        .nxt_lst_tid  (tr_lst_tid),
        .nxt_stride   (tr_stride),
        .fire         (tr_fire),
        .fire_addr    (tr_pf_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pf_v = 1'b0;
        alloc     = 1'b0;
        if (dem_valid) begin
            if (hit_any) begin
                st_d.tab[hit_idx].stage    = tr_stage;
                st_d.tab[hit_idx].anc_addr = tr_anc_addr;
                st_d.tab[hit_idx].anc_tid  = tr_anc_tid;
                st_d.tab[hit_idx].lst_addr = tr_lst_addr;
                st_d.tab[hit_idx].lst_tid  = tr_lst_tid;
                st_d.tab[hit_idx].stride   = tr_stride;
                st_d.pf_v                  = tr_fire;
                if (tr_fire) begin
                    st_d.pf_a = tr_pf_addr;
                end
            end else begin
                alloc                      = 1'b1;
                st_d.tab[vic_idx].stage    = ST_ANCHOR;
                st_d.tab[vic_idx].pc       = dem_pc;
                st_d.tab[vic_idx].anc_addr = dem_addr;
                st_d.tab[vic_idx].anc_tid  = dem_tid;
                st_d.tab[vic_idx].lst_addr = dem_addr;
                st_d.tab[vic_idx].lst_tid  = dem_tid;
                st_d.tab[vic_idx].stride   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pf_valid = st_q.pf_v;
    assign pf_addr  = st_q.pf_a;

endmodule

// File: rtl/xts_chk.sv
module xts_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dem_valid,
    input logic               pf_valid,
    input logic               hit_any,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] locked_vec,
    input logic [ENTRIES-1:0] pair_vec
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

    // R9
    pf_needs_demand_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        pf_valid |-> $past(dem_valid));

    // R8
    pf_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        pf_valid |-> $past(hit_any));

    // R2
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_lock
        // R4
        lock_via_pair_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
            $rose(locked_vec[i]) |-> $past(pair_vec[i]));
    end

endmodule

bind xthread_stride_pf xts_chk #(
    .ENTRIES (ENTRIES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dem_valid  (dem_valid),
    .pf_valid   (pf_valid),
    .hit_any    (hit_any),
    .hit_vec    (hit_vec),
    .locked_vec (locked_vec),
    .pair_vec   (pair_vec)
);

// File: tb/xthread_stride_pf_test.sv
`timescale 1ns/1ps
module xthread_stride_pf_test;

    localparam int PC_W   = 16;
    localparam int ADDR_W = 32;
    localparam int TID_W  = 10;
    localparam int DIST   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dem_valid = 1'b0;
    logic [PC_W-1:0]   dem_pc = '0;
    logic [ADDR_W-1:0] dem_addr = '0;
    logic [TID_W-1:0]  dem_tid = '0;
    logic              pf_valid;
    logic [ADDR_W-1:0] pf_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic              got_v;
    logic [ADDR_W-1:0] got_a;

    always #2.5 clk = ~clk;

    xthread_stride_pf uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dem_valid (dem_valid),
        .dem_pc    (dem_pc),
        .dem_addr  (dem_addr),
        .dem_tid   (dem_tid),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one request, result sampled one clock later, then one idle cycle
    task automatic send(input int pc, input longint addr, input int tid);
        @(negedge clk);
        dem_pc    = PC_W'(pc);
        dem_addr  = ADDR_W'(addr);
        dem_tid   = TID_W'(tid);
        dem_valid = 1'b1;
        @(negedge clk);
        got_v     = pf_valid;
        got_a     = pf_addr;
        dem_valid = 1'b0;
    endtask

    task automatic expect_none(input string req);
        check(req, 64'(got_v), 64'd0);
    endtask

    task automatic expect_pf(input string req, input longint addr);
        check({req, " valid"}, 64'(got_v), 64'd1);
        check({req, " addr"}, 64'(got_a), 64'(ADDR_W'(addr)));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", 64'(pf_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 64'(pf_valid), 64'd0);
    endtask

    task automatic t_basic();
        send('h1a, 200, 1);   expect_none("R4 first");
        send('h1a, 1100, 10); expect_none("R4 second");
        send('h1a, 400, 3);   expect_pf("R4 R5 third", 400 + 100 * DIST);
        @(negedge clk);
        check("R9 idle after pf", 64'(pf_valid), 64'd0);
        send('h1a, 2100, 20); expect_pf("R5 locked", 2100 + 100 * DIST);
    endtask

    task automatic t_inexact();
        send('h20, 1000, 0);  expect_none("R3 a");
        send('h20, 1100, 3);  expect_none("R3 inexact");
        send('h20, 1200, 4);  expect_none("R3 pair");
        send('h20, 1300, 5);  expect_pf("R3 lock", 1300 + 100 * DIST);
    endtask

    task automatic t_same_tid();
        send('h30, 500, 2);   expect_none("R6 anchor");
        send('h30, 999, 2);   expect_none("R6 dup ignored");
        send('h30, 520, 4);   expect_none("R6 pair");
        send('h30, 530, 5);   expect_pf("R6 lock", 530 + 10 * DIST);
        send('h30, 777, 5);   expect_pf("R6 locked dup", 777 + 10 * DIST);
        send('h30, 540, 6);   expect_pf("R6 last kept", 540 + 10 * DIST);
    endtask

    task automatic t_mismatch();
        send('h1a, 9000, 21); expect_none("R7 mismatch");
        send('h1a, 2200, 21); expect_none("R7 dup");
        send('h1a, 2300, 22); expect_none("R7 pair");
        send('h1a, 2400, 23); expect_none("R7 pair miss");
        send('h1a, 2500, 24); expect_none("R7 repair");
        send('h1a, 2600, 25); expect_pf("R7 relock", 2600 + 100 * DIST);
    endtask

    task automatic t_negative();
        send('h50, 8000, 0);  expect_none("R10 a");
        send('h50, 7960, 1);  expect_none("R10 b");
        send('h50, 7880, 3);  expect_pf("R10 down", 7880 - 40 * DIST);
    endtask

    task automatic t_interleave();
        send('h60, 0, 0);     expect_none("R2 A1");
        send('h61, 1000, 0);  expect_none("R2 B1");
        send('h60, 16, 2);    expect_none("R2 A2");
        send('h61, 1008, 2);  expect_none("R2 B2");
        send('h60, 24, 3);    expect_pf("R2 A3", 24 + 8 * DIST);
        send('h61, 1012, 3);  expect_pf("R2 B3", 1012 + 4 * DIST);
    endtask

    task automatic t_evict();
        do_reset();
        send('h70, 100, 0);
        send('h70, 110, 1);
        send('h70, 120, 2);   expect_pf("R8 trained", 120 + 10 * DIST);
        for (int k = 0; k < 15; k++) begin
            send('h100 + k, 64 * k, 1);
            expect_none("R8 fill");
        end
        send('h70, 130, 3);   expect_pf("R8 survives", 130 + 10 * DIST);
        send('h10f, 5, 1);    expect_none("R8 evicting alloc");
        send('h70, 140, 4);   expect_none("R8 evicted");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_inexact();
        t_same_tid();
        t_mismatch();
        t_negative();
        t_interleave();
        t_evict();
        repeat (2) @(negedge clk);
        check("R9 quiet end", 64'(pf_valid), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule